// File: doc/BRIEF.md
# Shadow Return-Address Checker

This block keeps a protected copy of return addresses alongside a processor's ordinary memory stack. Every call event pushes the return address into a small private register file. Every return event hands the block the address the core popped from the ordinary stack. The block compares it with the newest private entry. If the two differ, a tampered return has been found and the block raises a control-protection fault.

The private entries can only change in two ways: a push from a call event, or a dedicated privileged write port that sets one entry by index. That port stands for the special write instructions system software uses. Ordinary data stores have no path into the storage. Misuse of the stack is reported as a fault with its own cause code, as are empty returns, full calls and a call and return in one cycle. A fault stays raised until software acknowledges it.

Top module: `shadow_ret_stack`

## Requirements
- R1: A call event (callValid high, retValid low) with fewer than DEPTH entries stored writes callAddr into the entry at index stackDepth. stackDepth then grows by one in the next cycle.
- R2: A return event (retValid high, callValid low) with at least one entry compares retAddr with the entry at index stackDepth-1. The entry is always removed, so stackDepth shrinks by one. A match raises no fault.
- R3: A return whose retAddr differs from the newest entry raises a fault with cause code 1 (mismatch). The entry is still removed.
- R4: A return event with no entries stored raises cause code 2 (underflow). stackDepth stays 0.
- R5: A call event with DEPTH entries stored raises cause code 3 (overflow). It stores nothing, and stackDepth stays DEPTH.
- R6: callValid and retValid high in the same cycle raise cause code 4 (protocol error). The stack contents and stackDepth do not change.
- R7: Faults are registered. faultValid and faultCause show a fault one cycle after the event that caused it. While faultValid is high and faultAck is low, both outputs hold, and the first cause is kept. A cycle with faultAck high (or with no fault pending) loads that cycle's new cause if there is one. Otherwise it clears faultValid and sets faultCause to 0.
- R8: privWrEn high writes privWrData into entry privWrIdx and leaves stackDepth unchanged. If it targets the same entry as a push in the same cycle, the privileged data is the value kept.
- R9: After reset, stackDepth is 0, faultValid is 0 and faultCause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| callValid | input | 1 | Call event this cycle |
| callAddr | input | AW | Return address to store on a call |
| retValid | input | 1 | Return event this cycle |
| retAddr | input | AW | Address popped from the ordinary stack |
| privWrEn | input | 1 | Privileged entry write |
| privWrIdx | input | log2(DEPTH) | Entry index for the privileged write |
| privWrData | input | AW | Data for the privileged write |
| faultAck | input | 1 | Software acknowledge of the pending fault |
| faultValid | output | 1 | Control-protection fault pending |
| faultCause | output | 3 | 0 none, 1 mismatch, 2 underflow, 3 overflow, 4 protocol |
| stackDepth | output | log2(DEPTH+1) | Number of stored entries |

## Verification
The bench fills the stack completely and then issues one more call. A design with an off-by-one full test would either wrap and corrupt entry 0 or miss the overflow. It then drains the stack, returning once with a wrong address to confirm that the entry is still removed, and finishes with an empty return for underflow. Several cases target the fault register: a second fault raised while one is pending must not replace the first cause, and an acknowledge arriving with a new fault must load the new cause rather than drop it. Privileged writes are checked both on the top entry and in the same cycle as a push to the same index; a wrong write priority shows up as a false mismatch on the next return.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_MISMATCH  = 3'd1,
    CAUSE_UNDERFLOW = 3'd2,
    CAUSE_OVERFLOW  = 3'd3,
    CAUSE_PROTOCOL  = 3'd4
  } faultCause_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;   // write callAddr at current pointer
    logic check;  // compare retAddr against newest entry
  } srsStrobe_t;

endpackage

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int AW    = 64,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  srsStrobe_t    strb,
  input  logic [PW-1:0] ptr,
  input  logic [AW-1:0] callAddr,
  input  logic [AW-1:0] retAddr,
  input  logic          privWrEn,
  input  logic [IW-1:0] privWrIdx,
  input  logic [AW-1:0] privWrData,
  output logic          mismatch
);

  logic [AW-1:0] entry [DEPTH];
  logic [IW-1:0] pushIdx;
  logic [IW-1:0] topIdx;
  logic [PW-1:0] ptrMinus1;

  assign pushIdx   = ptr[IW-1:0];
  assign ptrMinus1 = ptr - PW'(1);
  assign topIdx    = ptrMinus1[IW-1:0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry[i] <= '0;
      end else if (privWrEn && privWrIdx == IW'(i)) begin
        entry[i] <= privWrData;            // privileged path wins
      end else if (strb.push && pushIdx == IW'(i)) begin
        entry[i] <= callAddr;
      end
    end
  end

  assign mismatch = strb.check && (entry[topIdx] != retAddr);

endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          callValid,
  input  logic          retValid,
  input  logic          mismatch,
  input  logic          faultAck,
  output srsStrobe_t    strb,
  output logic [PW-1:0] ptr,
  output logic          faultValid,
  output faultCause_e   faultCause
);

  logic        isFull, isEmpty, bothEvents;
  faultCause_e newCause;

  assign isFull     = (ptr == PW'(DEPTH));
  assign isEmpty    = (ptr == '0);
  assign bothEvents = callValid && retValid;

  always_comb begin
    strb.push  = callValid && !retValid && !isFull;
    strb.check = retValid && !callValid && !isEmpty;
  end

  always_comb begin
    if (bothEvents)                 newCause = CAUSE_PROTOCOL;
    else if (callValid && isFull)   newCause = CAUSE_OVERFLOW;
    else if (retValid && isEmpty)   newCause = CAUSE_UNDERFLOW;
    else if (mismatch)              newCause = CAUSE_MISMATCH;
    else                            newCause = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (strb.push) begin
      ptr <= ptr + PW'(1);
    end else if (strb.check) begin
      ptr <= ptr - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faultValid <= 1'b0;
      faultCause <= CAUSE_NONE;
    end else if (faultValid && !faultAck) begin
      faultValid <= 1'b1;                  // hold first cause
    end else if (newCause != CAUSE_NONE) begin
      faultValid <= 1'b1;
      faultCause <= newCause;
    end else begin
      faultValid <= 1'b0;
      faultCause <= CAUSE_NONE;
    end
  end

endmodule

// File: rtl/shadow_ret_stack.sv
module shadow_ret_stack
  import srs_pkg::*;
#(
  parameter int AW    = 64,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          callValid,
  input  logic [AW-1:0] callAddr,
  input  logic          retValid,
  input  logic [AW-1:0] retAddr,
  input  logic          privWrEn,
  input  logic [IW-1:0] privWrIdx,
  input  logic [AW-1:0] privWrData,
  input  logic          faultAck,
  output logic          faultValid,
  output logic [2:0]    faultCause,
  output logic [PW-1:0] stackDepth
);

  srsStrobe_t  strb;
  logic        mismatch;
  faultCause_e causeQ;

  srs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .callValid  (callValid),
    .retValid   (retValid),
    .mismatch   (mismatch),
    .faultAck   (faultAck),
    .strb       (strb),
    .ptr        (stackDepth),
    .faultValid (faultValid),
    .faultCause (causeQ)
  );

  srs_datapath #(.AW(AW), .DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .ptr        (stackDepth),
    .callAddr   (callAddr),
    .retAddr    (retAddr),
    .privWrEn   (privWrEn),
    .privWrIdx  (privWrIdx),
    .privWrData (privWrData),
    .mismatch   (mismatch)
  );

  assign faultCause = causeQ;

endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          callValid,
  input logic          retValid,
  input logic          privWrEn,
  input logic          faultAck,
  input logic          faultValid,
  input logic [2:0]    faultCause,
  input logic [PW-1:0] stackDepth
);

  logic canLoad;
  assign canLoad = !faultValid || faultAck;

  p_depth_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stackDepth <= PW'(DEPTH));

  p_call_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
    callValid && !retValid && stackDepth != PW'(DEPTH)
    |=> stackDepth == $past(stackDepth) + PW'(1));

  p_ret_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    retValid && !callValid && stackDepth != '0
    |=> stackDepth == $past(stackDepth) - PW'(1));

  p_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    canLoad && retValid && !callValid && stackDepth == '0
    |=> faultValid && faultCause == 3'd2 && stackDepth == '0);

  p_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    canLoad && callValid && !retValid && stackDepth == PW'(DEPTH)
    |=> faultValid && faultCause == 3'd3 && stackDepth == PW'(DEPTH));

  p_proto_depth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    callValid && retValid |=> $stable(stackDepth));

  p_proto_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    canLoad && callValid && retValid |=> faultValid && faultCause == 3'd4);

  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    faultValid && !faultAck |=> faultValid && $stable(faultCause));

  p_priv_no_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    privWrEn && !callValid && !retValid |=> $stable(stackDepth));

endmodule

bind shadow_ret_stack srs_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .callValid  (callValid),
  .retValid   (retValid),
  .privWrEn   (privWrEn),
  .faultAck   (faultAck),
  .faultValid (faultValid),
  .faultCause (faultCause),
  .stackDepth (stackDepth)
);

// File: tb/tb_shadow_ret_stack.sv
`timescale 1ns/1ps
module tb_shadow_ret_stack;

  localparam int AW = 64;
  localparam int DEPTH = 16;
  localparam int IW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic callValid = 0, retValid = 0, privWrEn = 0, faultAck = 0;
  logic [AW-1:0] callAddr = '0, retAddr = '0, privWrData = '0;
  logic [IW-1:0] privWrIdx = '0;
  logic faultValid;
  logic [2:0] faultCause;
  logic [PW-1:0] stackDepth;

  always #2.5 clk = ~clk;

  shadow_ret_stack #(.AW(AW), .DEPTH(DEPTH)) dut (.*);

  // reference model
  logic [AW-1:0] m [DEPTH];
  int mDepth = 0;
  bit mFv = 0;
  int mFc = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic int calcCause(bit c, bit r, logic [AW-1:0] ra);
    if (c && r) return 4;
    if (c && mDepth == DEPTH) return 3;
    if (r && mDepth == 0) return 2;
    if (r && m[mDepth-1] != ra) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit c, logic [AW-1:0] ca, bit r, logic [AW-1:0] ra,
                      bit pw, logic [IW-1:0] pi, logic [AW-1:0] pd,
                      bit ack, string tag);
    int cause;
    @(negedge clk);
    callValid = c; callAddr = ca; retValid = r; retAddr = ra;
    privWrEn = pw; privWrIdx = pi; privWrData = pd; faultAck = ack;
    cause = calcCause(c, r, ra);
    if (!(mFv && !ack)) begin
      mFv = (cause != 0);
      mFc = cause;
    end
    if (c && !r && mDepth < DEPTH) begin
      m[mDepth] = ca;
      mDepth++;
    end else if (r && !c && mDepth > 0) begin
      mDepth--;
    end
    if (pw) m[pi] = pd;
    @(posedge clk);
    #1;
    chk(tag, "stackDepth", longint'(stackDepth), longint'(mDepth));
    chk(tag, "faultValid", longint'(faultValid), longint'(mFv));
    chk(tag, "faultCause", longint'(faultCause), longint'(mFc));
  endtask

  task automatic idle(bit ack, string tag);
    step(0, '0, 0, '0, 0, '0, '0, ack, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "stackDepth", longint'(stackDepth), 0);
    chk("R9", "faultValid", longint'(faultValid), 0);
    chk("R9", "faultCause", longint'(faultCause), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: fill the stack
    for (int i = 0; i < DEPTH; i++)
      step(1, 64'h1000_0000_0000_0000 + 64'(i * 4), 0, '0, 0, '0, '0, 0, "R1");
    // R5: overflow on full stack
    step(1, 64'hdead, 0, '0, 0, '0, '0, 0, "R5");
    idle(0, "R7");
    idle(1, "R7");
    // R2: matching returns
    for (int i = DEPTH - 1; i > DEPTH - 4; i--)
      step(0, '0, 1, 64'h1000_0000_0000_0000 + 64'(i * 4), 0, '0, '0, 0, "R2");
    // R3: mismatch still pops
    step(0, '0, 1, 64'hbad0_bad0, 0, '0, '0, 0, "R3");
    // R7: second fault while pending keeps first cause
    step(1, 64'h2, 1, 64'h2, 0, '0, '0, 0, "R7");
    idle(0, "R7");
    // R7: ack with new fault loads new cause (protocol, R6)
    step(1, 64'h3, 1, 64'h3, 0, '0, '0, 1, "R6");
    idle(1, "R7");
    // R8: privileged write on top entry, then matching return
    step(0, '0, 0, '0, 1, IW'(mDepth - 1), 64'hcafe_f00d, 0, "R8");
    step(0, '0, 1, 64'hcafe_f00d, 0, '0, '0, 0, "R8");
    // R8: privileged write wins over push to same index
    step(1, 64'h1111, 0, '0, 1, IW'(mDepth), 64'h2222, 0, "R8");
    step(0, '0, 1, 64'h2222, 0, '0, '0, 0, "R8");
    // drain then R4 underflow
    while (mDepth > 0) step(0, '0, 1, m[mDepth-1], 0, '0, '0, 0, "R2");
    step(0, '0, 1, 64'h5, 0, '0, '0, 0, "R4");
    idle(1, "R7");
    idle(0, "R7");

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int sel;
      bit c, r, pw, ack;
      logic [AW-1:0] ca, ra;
      string tag;
      sel = int'($urandom % 16);
      c = (sel < 6) || (sel == 12);
      r = (sel >= 6 && sel < 12) || (sel == 12);
      ca = {$urandom, $urandom};
      if (mDepth > 0 && ($urandom % 4) != 0) ra = m[mDepth-1];
      else ra = {$urandom, $urandom};
      pw = (($urandom % 8) == 0);
      ack = (($urandom % 3) == 0);
      case (calcCause(c, r, ra))
        1: tag = "R3";
        2: tag = "R4";
        3: tag = "R5";
        4: tag = "R6";
        default: tag = c ? "R1" : (r ? "R2" : "R8");
      endcase
      step(c, ca, r, ra, pw, IW'($urandom), {$urandom, $urandom}, ack, tag);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule